// File: doc/BRIEF.md
# Calorimeter Trigger Decision Logic

This block sits at the end of the calorimeter trigger path. A set of digitizer links each deliver a frame for a group of trigger cells. Every frame carries a pulse height and a hit flag for each cell. The links reach the block with different delays. Each link therefore feeds its own small queue. An event slot is formed only when every queue holds a frame. All queues are then popped together, so the frames of one event meet in a single cycle no matter when each link delivered its part.

From the aligned event the block forms three kinds of decision. Three energy threshold bits compare the exact sum of all cell heights against three programmable levels. A cluster count gives the number of isolated hit cells, with a carry bit for counts above seven. Three region timing bits cover the forward, barrel and backward cell ranges, and an overall bit is the OR of those three. A decision takes four pipeline cycles after the clock edge that accepts the last missing frame. It is presented as a one-cycle pulse with a valid strobe.

Top module: `cal_trig_top`

## Requirements
- R1: While reset is held, and until the first event, `evt_valid`, `e_sum`, `e_thr`, `e_cnt`, `e_carry` and `e_tim` are all zero.
- R2: An event is formed only when every link queue holds a frame. One frame from every queue is then consumed together. `evt_valid` rises in the fourth cycle after the clock edge that accepted the last missing frame.
- R3: `e_sum` equals the exact sum of all 624 cell heights, with no overflow. `e_thr[0]`, `e_thr[1]` and `e_thr[2]` are set when the sum is greater than or equal to `thr_lo`, `thr_mid` and `thr_hi` respectively.
- R4: Cells are numbered `link*12 + cell`. A cell is an isolated cluster when its hit bit is set and the hit bits of cells n-1 and n+1 are clear. A neighbour beyond either end counts as clear, and neighbours across a link boundary are compared like any others.
- R5: With n isolated clusters, `e_cnt` is min(n,7) and `e_carry` is set exactly when n > 7.
- R6: `e_tim[1]`, `e_tim[2]` and `e_tim[3]` (forward, barrel, backward) are set when any hit cell lies in cells 0–95, 96–527 or 528–623 respectively.
- R7: `e_tim[0]` is set when any of the three region bits is set.
- R8: All decision outputs are zero in every cycle where `evt_valid` is low, so each decision lasts exactly one cycle.
- R9: A link queue holds 4 frames. A frame presented to a full queue is dropped and never forms an event.
- R10: Events whose last frames arrive on consecutive cycles give decisions on consecutive cycles, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| link_valid | input | 52 | One strobe per link: a frame is present this cycle |
| link_data | input | 8112 | 52 frames of 156 bits. In each frame, cell c height is at bits c*12+11..c*12 and cell c hit flag is at bit 144+c |
| thr_lo | input | 22 | Lowest energy threshold in ADC counts |
| thr_mid | input | 22 | Middle energy threshold |
| thr_hi | input | 22 | Highest energy threshold |
| evt_valid | output | 1 | One-cycle strobe marking a decision |
| e_sum | output | 22 | Total height of the event |
| e_thr | output | 3 | Threshold bits, low to high |
| e_cnt | output | 3 | Saturated isolated cluster count |
| e_carry | output | 1 | Cluster count exceeded seven |
| e_tim | output | 4 | Timing bits: overall, forward, barrel, backward |

## Verification
Two functions can fall in the same cycle: a link queue accepting a new frame, and the same queue being popped for the event in front of it. The bench provokes this by presenting complete events on back-to-back cycles. It also preloads one link several frames deep while the other links catch up one frame per cycle. The outcome is judged by requiring every decision to appear, in order, exactly one cycle after the previous one with its own sum. A frame presented to an already full queue must never appear as an event.

// File: rtl/cal_trig_pkg.sv
`timescale 1ns/1ps
package cal_trig_pkg;
  localparam int N_THR = 3;
  localparam int CNT_W = 3;
  localparam int N_REG = 3;

  typedef struct packed {
    logic [N_THR-1:0] thr;
    logic [CNT_W-1:0] cnt;
    logic             carry;
    logic [N_REG:0]   tim;
  } trig_word_t;

  function automatic logic [CNT_W:0] sat_count(input logic [15:0] n);
    logic [CNT_W:0] r;
    if (n > 16'((1 << CNT_W) - 1)) r = {1'b1, {CNT_W{1'b1}}};
    else                            r = {1'b0, n[CNT_W-1:0]};
    return r;
  endfunction
endpackage

// File: rtl/link_fifo.sv
`timescale 1ns/1ps
module link_fifo #(
  parameter int W     = 156,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         nonempty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_q, wr_d, rd_q, rd_d;
  logic         full, push_ok;

  assign full     = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign nonempty = (wr_q != rd_q);
  assign push_ok  = push && !full;
  assign dout     = mem[rd_q[AW-1:0]];

  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (push_ok)            wr_d = wr_q + 1'b1;
    if (pop && nonempty)    rd_d = rd_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q[AW-1:0]] <= din;
  end
endmodule

// File: rtl/energy_sum.sv
`timescale 1ns/1ps
module energy_sum #(
  parameter int N_LINK = 52,
  parameter int N_CELL = 12,
  parameter int HW     = 12,
  parameter int SUMW   = 22
) (
  input  logic                     clk,
  input  logic                     rst_sn,
  input  logic                     en_part,
  input  logic                     en_tot,
  input  logic [N_LINK*N_CELL*HW-1:0] heights,
  output logic [SUMW-1:0]          sum_q
);
  localparam int PW = HW + $clog2(N_CELL);

  logic [PW-1:0]   part_d [N_LINK];
  logic [PW-1:0]   part_q [N_LINK];
  logic [SUMW-1:0] sum_d;

  always_comb begin
    for (int l = 0; l < N_LINK; l++) begin
      part_d[l] = '0;
      for (int c = 0; c < N_CELL; c++)
        part_d[l] = part_d[l] + PW'(heights[(l*N_CELL+c)*HW +: HW]);
    end
  end

  always_comb begin
    sum_d = '0;
    for (int l = 0; l < N_LINK; l++)
      sum_d = sum_d + SUMW'(part_q[l]);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      for (int l = 0; l < N_LINK; l++) part_q[l] <= '0;
      sum_q <= '0;
    end else begin
      if (en_part)
        for (int l = 0; l < N_LINK; l++) part_q[l] <= part_d[l];
      if (en_tot) sum_q <= sum_d;
    end
  end
endmodule

// File: rtl/cluster_count.sv
`timescale 1ns/1ps
module cluster_count #(
  parameter int N_LINK = 52,
  parameter int N_CELL = 12,
  parameter int CW     = 10
) (
  input  logic                     clk,
  input  logic                     rst_sn,
  input  logic                     en_part,
  input  logic                     en_tot,
  input  logic [N_LINK*N_CELL-1:0] hits,
  output logic [CW-1:0]            cnt_q
);
  localparam int NT  = N_LINK * N_CELL;
  localparam int PCW = $clog2(N_CELL + 1);

  logic [NT-1:0]  iso;
  logic [PCW-1:0] pc_d [N_LINK];
  logic [PCW-1:0] pc_q [N_LINK];
  logic [CW-1:0]  cnt_d;

  for (genvar g = 0; g < NT; g++) begin : g_iso
    if (g == 0) begin : g_first
      assign iso[g] = hits[g] & ~hits[g+1];
    end else if (g == NT - 1) begin : g_last
      assign iso[g] = hits[g] & ~hits[g-1];
    end else begin : g_mid
      assign iso[g] = hits[g] & ~hits[g-1] & ~hits[g+1];
    end
  end

  always_comb begin
    for (int l = 0; l < N_LINK; l++) begin
      pc_d[l] = '0;
      for (int c = 0; c < N_CELL; c++)
        pc_d[l] = pc_d[l] + {{(PCW-1){1'b0}}, iso[l*N_CELL+c]};
    end
  end

  always_comb begin
    cnt_d = '0;
    for (int l = 0; l < N_LINK; l++)
      cnt_d = cnt_d + CW'(pc_q[l]);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      for (int l = 0; l < N_LINK; l++) pc_q[l] <= '0;
      cnt_q <= '0;
    end else begin
      if (en_part)
        for (int l = 0; l < N_LINK; l++) pc_q[l] <= pc_d[l];
      if (en_tot) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/region_timing.sv
`timescale 1ns/1ps
module region_timing #(
  parameter int NT     = 624,
  parameter int FWD_LO = 0,
  parameter int FWD_HI = 95,
  parameter int BAR_LO = 96,
  parameter int BAR_HI = 527,
  parameter int BWD_LO = 528,
  parameter int BWD_HI = 623
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          en_part,
  input  logic          en_tot,
  input  logic [NT-1:0] hits,
  output logic [2:0]    reg_q
);
  logic [NT-1:0] m_fwd, m_bar, m_bwd;
  logic [2:0]    reg_d, reg_s2;

  for (genvar g = 0; g < NT; g++) begin : g_mask
    assign m_fwd[g] = (g >= FWD_LO) && (g <= FWD_HI);
    assign m_bar[g] = (g >= BAR_LO) && (g <= BAR_HI);
    assign m_bwd[g] = (g >= BWD_LO) && (g <= BWD_HI);
  end

  assign reg_d = {|(hits & m_bwd), |(hits & m_bar), |(hits & m_fwd)};

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      reg_s2 <= '0;
      reg_q  <= '0;
    end else begin
      if (en_part) reg_s2 <= reg_d;
      if (en_tot)  reg_q  <= reg_s2;
    end
  end
endmodule

// File: rtl/cal_trig_top.sv
`timescale 1ns/1ps
module cal_trig_top
  import cal_trig_pkg::*;
#(
  parameter  int N_LINK = 52,
  parameter  int N_CELL = 12,
  parameter  int HW     = 12,
  parameter  int DEPTH  = 4,
  parameter  int FWD_LO = 0,
  parameter  int FWD_HI = 95,
  parameter  int BAR_LO = 96,
  parameter  int BAR_HI = 527,
  parameter  int BWD_LO = 528,
  parameter  int BWD_HI = 623,
  localparam int NT     = N_LINK * N_CELL,
  localparam int FW     = N_CELL * (HW + 1),
  localparam int SUMW   = HW + $clog2(NT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_LINK-1:0]    link_valid,
  input  logic [N_LINK*FW-1:0] link_data,
  input  logic [SUMW-1:0]      thr_lo,
  input  logic [SUMW-1:0]      thr_mid,
  input  logic [SUMW-1:0]      thr_hi,
  output logic                 evt_valid,
  output logic [SUMW-1:0]      e_sum,
  output logic [2:0]           e_thr,
  output logic [2:0]           e_cnt,
  output logic                 e_carry,
  output logic [3:0]           e_tim
);
  localparam int CW = $clog2(NT + 1);

  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic [FW-1:0]     head [N_LINK];
  logic [N_LINK-1:0] ready;
  logic              pop_all;
  logic [NT*HW-1:0]  hgt_d, hgt_q;
  logic [NT-1:0]     hit_d, hit_q;

  assign pop_all = &ready;

  for (genvar l = 0; l < N_LINK; l++) begin : g_link
    link_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_sn   (rst_sn),
      .push     (link_valid[l]),
      .din      (link_data[l*FW +: FW]),
      .pop      (pop_all),
      .dout     (head[l]),
      .nonempty (ready[l])
    );
    for (genvar c = 0; c < N_CELL; c++) begin : g_cell
      assign hgt_d[(l*N_CELL+c)*HW +: HW] = head[l][c*HW +: HW];
      assign hit_d[l*N_CELL+c]            = head[l][N_CELL*HW + c];
    end
  end

  logic v1, v2, v3;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      hgt_q <= '0;
      hit_q <= '0;
      v1    <= 1'b0;
      v2    <= 1'b0;
      v3    <= 1'b0;
    end else begin
      if (pop_all) begin
        hgt_q <= hgt_d;
        hit_q <= hit_d;
      end
      v1 <= pop_all;
      v2 <= v1;
      v3 <= v2;
    end
  end

  logic [SUMW-1:0] sum3;
  logic [CW-1:0]   cnt3;
  logic [2:0]      reg3;

  energy_sum #(.N_LINK(N_LINK), .N_CELL(N_CELL), .HW(HW), .SUMW(SUMW)) u_sum (
    .clk(clk), .rst_sn(rst_sn), .en_part(v1), .en_tot(v2),
    .heights(hgt_q), .sum_q(sum3)
  );

  cluster_count #(.N_LINK(N_LINK), .N_CELL(N_CELL), .CW(CW)) u_clu (
    .clk(clk), .rst_sn(rst_sn), .en_part(v1), .en_tot(v2),
    .hits(hit_q), .cnt_q(cnt3)
  );

  region_timing #(.NT(NT), .FWD_LO(FWD_LO), .FWD_HI(FWD_HI), .BAR_LO(BAR_LO),
                  .BAR_HI(BAR_HI), .BWD_LO(BWD_LO), .BWD_HI(BWD_HI)) u_reg (
    .clk(clk), .rst_sn(rst_sn), .en_part(v1), .en_tot(v2),
    .hits(hit_q), .reg_q(reg3)
  );

  trig_word_t      word_d, word_q;
  logic [SUMW-1:0] sum_d, sum_q;
  logic            evt_q;
  logic [CNT_W:0]  sat;

  assign sat = sat_count(16'(cnt3));

  always_comb begin
    word_d = '0;
    sum_d  = '0;
    if (v3) begin
      sum_d        = sum3;
      word_d.thr   = {sum3 >= thr_hi, sum3 >= thr_mid, sum3 >= thr_lo};
      word_d.cnt   = sat[CNT_W-1:0];
      word_d.carry = sat[CNT_W];
      word_d.tim   = {reg3, |reg3};
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      word_q <= '0;
      sum_q  <= '0;
      evt_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      sum_q  <= sum_d;
      evt_q  <= v3;
    end
  end

  assign evt_valid = evt_q;
  assign e_sum     = sum_q;
  assign e_thr     = word_q.thr;
  assign e_cnt     = word_q.cnt;
  assign e_carry   = word_q.carry;
  assign e_tim     = word_q.tim;
endmodule

// File: rtl/cal_trig_chk.sv
`timescale 1ns/1ps
module cal_trig_chk #(
  parameter int SUMW = 22
) (
  input logic            clk,
  input logic            rst_sn,
  input logic            pop_all,
  input logic            evt_valid,
  input logic [SUMW-1:0] e_sum,
  input logic [2:0]      e_thr,
  input logic [2:0]      e_cnt,
  input logic            e_carry,
  input logic [3:0]      e_tim,
  input logic [SUMW-1:0] thr_lo,
  input logic [SUMW-1:0] thr_mid,
  input logic [SUMW-1:0] thr_hi
);
  assert_pop_to_event_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    pop_all |-> ##4 evt_valid);

  assert_event_has_pop_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    (evt_valid && $past(rst_sn, 4)) |-> $past(pop_all, 4));

  assert_graded_hi_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (evt_valid && e_thr[2] && $past(thr_mid <= thr_hi)) |-> e_thr[1]);

  assert_graded_mid_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (evt_valid && e_thr[1] && $past(thr_lo <= thr_mid)) |-> e_thr[0]);

  assert_carry_saturates_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    e_carry |-> (e_cnt == 3'd7));

  assert_cluster_has_hit_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    ((e_cnt != 3'd0) || e_carry) |-> e_tim[0]);

  assert_quiet_between_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    !evt_valid |-> (e_thr == 3'd0 && e_cnt == 3'd0 && !e_carry && e_tim == 4'd0 && e_sum == '0));
endmodule

bind cal_trig_top cal_trig_chk #(.SUMW(SUMW)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .pop_all(pop_all), .evt_valid(evt_valid),
  .e_sum(e_sum), .e_thr(e_thr), .e_cnt(e_cnt), .e_carry(e_carry), .e_tim(e_tim),
  .thr_lo(thr_lo), .thr_mid(thr_mid), .thr_hi(thr_hi)
);

// File: tb/sim_cal_trig_top.sv
`timescale 1ns/1ps
module sim_cal_trig_top;
  localparam int NL   = 52;
  localparam int NC   = 12;
  localparam int HW   = 12;
  localparam int NT   = NL * NC;
  localparam int FW   = NC * (HW + 1);
  localparam int SUMW = 22;

  typedef struct packed {
    logic [3:0]  mode;
    logic [11:0] arg;
    logic [21:0] sum;
    logic [2:0]  thr;
    logic [2:0]  cnt;
    logic        carry;
    logic [3:0]  tim;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{4'd0, 12'd0,    22'd0,       3'b000, 3'd0, 1'b0, 4'b0000},
    '{4'd0, 12'd1,    22'd624,     3'b000, 3'd0, 1'b0, 4'b0000},
    '{4'd0, 12'd2,    22'd1248,    3'b001, 3'd0, 1'b0, 4'b0000},
    '{4'd0, 12'd100,  22'd62400,   3'b011, 3'd0, 1'b0, 4'b0000},
    '{4'd0, 12'd4095, 22'd2555280, 3'b111, 3'd0, 1'b0, 4'b0000},
    '{4'd1, 12'd1,    22'd0,       3'b000, 3'd0, 1'b0, 4'b1111},
    '{4'd1, 12'd2,    22'd0,       3'b000, 3'd7, 1'b1, 4'b1111},
    '{4'd1, 12'd100,  22'd0,       3'b000, 3'd7, 1'b0, 4'b1111},
    '{4'd1, 12'd78,   22'd0,       3'b000, 3'd7, 1'b1, 4'b1111},
    '{4'd2, 12'd0,    22'd100,     3'b000, 3'd1, 1'b0, 4'b0011},
    '{4'd2, 12'd623,  22'd100,     3'b000, 3'd1, 1'b0, 4'b1001},
    '{4'd2, 12'd95,   22'd100,     3'b000, 3'd1, 1'b0, 4'b0011},
    '{4'd2, 12'd96,   22'd100,     3'b000, 3'd1, 1'b0, 4'b0101},
    '{4'd3, 12'd11,   22'd0,       3'b000, 3'd0, 1'b0, 4'b0011},
    '{4'd4, 12'd1000, 22'd1000,    3'b001, 3'd0, 1'b0, 4'b0000},
    '{4'd4, 12'd999,  22'd999,     3'b000, 3'd0, 1'b0, 4'b0000}
  };

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [NL-1:0]        link_valid;
  logic [NL*FW-1:0]     link_data;
  logic [SUMW-1:0]      thr_lo, thr_mid, thr_hi;
  logic                 evt_valid;
  logic [SUMW-1:0]      e_sum;
  logic [2:0]           e_thr;
  logic [2:0]           e_cnt;
  logic                 e_carry;
  logic [3:0]           e_tim;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  cal_trig_top u0 (
    .clk(clk), .rst_n(rst_n), .link_valid(link_valid), .link_data(link_data),
    .thr_lo(thr_lo), .thr_mid(thr_mid), .thr_hi(thr_hi),
    .evt_valid(evt_valid), .e_sum(e_sum), .e_thr(e_thr), .e_cnt(e_cnt),
    .e_carry(e_carry), .e_tim(e_tim)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cell(input int i, input logic [11:0] h, input logic hit);
    link_data[(i/NC)*FW + (i%NC)*HW +: HW] = h;
    link_data[(i/NC)*FW + NC*HW + (i%NC)]  = hit;
  endtask

  task automatic make_frame(input logic [3:0] mode, input logic [11:0] arg);
    link_data = '0;
    for (int i = 0; i < NT; i++) begin
      case (mode)
        4'd0: set_cell(i, arg, 1'b0);
        4'd1: if (i % int'(arg) == 0) set_cell(i, 12'd0, 1'b1);
        4'd2: if (i == int'(arg)) set_cell(i, 12'd100, 1'b1);
        4'd3: if (i == int'(arg) || i == int'(arg) + 1) set_cell(i, 12'd0, 1'b1);
        default: if (i == 0) set_cell(i, arg, 1'b0);
      endcase
    end
  endtask

  task automatic check_outputs(input string tag, input vec_t v);
    chk({"R2 evt_valid ", tag}, 32'(evt_valid), 32'd1);
    chk({"R3 e_sum ", tag},     32'(e_sum),     32'(v.sum));
    chk({"R3 e_thr ", tag},     32'(e_thr),     32'(v.thr));
    chk({"R4 R5 e_cnt ", tag},  32'(e_cnt),     32'(v.cnt));
    chk({"R5 e_carry ", tag},   32'(e_carry),   32'(v.carry));
    chk({"R6 R7 e_tim ", tag},  32'(e_tim),     32'(v.tim));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    link_valid = '0;
    link_data  = '0;
    thr_lo     = 22'd1000;
    thr_mid    = 22'd50000;
    thr_hi     = 22'd1000000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 evt_valid in reset", 32'(evt_valid), 32'd0);
    chk("R1 e_sum in reset",     32'(e_sum),     32'd0);
    chk("R1 e_tim in reset",     32'(e_tim),     32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 outputs after reset", 32'({evt_valid, e_thr, e_cnt, e_carry, e_tim}), 32'd0);

    // table walk: R3 R4 R5 R6 R7
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      make_frame(VEC[k].mode, VEC[k].arg);
      link_valid = '1;
      @(posedge clk);
      @(negedge clk);
      link_valid = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R2 no early decision", 32'(evt_valid), 32'd0);
      @(posedge clk);
      @(negedge clk);
      check_outputs($sformatf("vec%0d", k), VEC[k]);
      @(posedge clk);
      @(negedge clk);
      chk("R8 pulse ends", 32'({evt_valid, e_thr, e_cnt, e_carry, e_tim}), 32'd0);
      chk("R8 sum cleared", 32'(e_sum), 32'd0);
    end

    // R2: skewed links
    @(negedge clk);
    make_frame(4'd0, 12'd1);
    link_valid = {{(NL/2){1'b0}}, {(NL/2){1'b1}}};
    @(posedge clk);
    @(negedge clk);
    link_valid = '0;
    for (int w = 0; w < 6; w++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R2 waits for all links", 32'(evt_valid), 32'd0);
    end
    link_valid = {{(NL/2){1'b1}}, {(NL/2){1'b0}}};
    @(posedge clk);
    @(negedge clk);
    link_valid = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R2 skewed event valid", 32'(evt_valid), 32'd1);
    chk("R2 skewed event sum",   32'(e_sum),     32'd624);

    // R10: back-to-back events
    repeat (3) @(posedge clk);
    @(negedge clk);
    make_frame(4'd0, 12'd1);
    link_valid = '1;
    @(posedge clk);
    @(negedge clk);
    make_frame(4'd0, 12'd2);
    @(posedge clk);
    @(negedge clk);
    link_valid = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 first valid",  32'(evt_valid), 32'd1);
    chk("R10 first sum",    32'(e_sum),     32'd624);
    @(posedge clk);
    @(negedge clk);
    chk("R10 second valid", 32'(evt_valid), 32'd1);
    chk("R10 second sum",   32'(e_sum),     32'd1248);
    chk("R10 second thr",   32'(e_thr),     32'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R10 then idle",    32'(evt_valid), 32'd0);

    // R9: link 0 gets five frames, only four fit
    repeat (3) @(posedge clk);
    for (int f = 1; f <= 5; f++) begin
      @(negedge clk);
      make_frame(4'd4, 12'(f));
      link_valid = {{(NL-1){1'b0}}, 1'b1};
      @(posedge clk);
    end
    @(negedge clk);
    link_valid = '0;
    link_data  = '0;
    for (int r = 0; r < 5; r++) begin
      @(negedge clk);
      link_valid = {{(NL-1){1'b1}}, 1'b0};
      @(posedge clk);
    end
    @(negedge clk);
    link_valid = '0;
    for (int f = 1; f <= 4; f++) begin
      chk("R9 queued event valid", 32'(evt_valid), 32'd1);
      chk("R9 queued event order", 32'(e_sum),     32'(f));
      @(posedge clk);
      @(negedge clk);
    end
    for (int w = 0; w < 6; w++) begin
      chk("R9 dropped frame gives no event", 32'(evt_valid), 32'd0);
      @(posedge clk);
      @(negedge clk);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule